// File: doc/BRIEF.md
# Broadcast Storm Rate Limiter

This block sits on the receive side of one switch port. It decides, frame by frame, whether a broadcast frame should be accepted or discarded, so that a flood of broadcasts cannot use up forwarding bandwidth and queue space on the other ports. Multicast frames can optionally be treated the same way. The block sees only a frame-start strobe with two classification flags. It reports a verdict that the buffer manager acts on.

Time is cut into repeating measurement windows. At 100 Mb/s a window lasts `WIN_FAST` clock cycles, which corresponds to 67 ms in the target system. At 10 Mb/s a window is exactly ten times longer. Each window starts with a zero count. Every qualifying frame that is accepted raises the count by one. Once the count equals the 11-bit global limit, the remaining qualifying frames in that window are marked for drop.

A typical limit is 99. That is roughly 1% of the 148,800 minimum-size frames per second that 100 Mb/s can carry, taken over one 67 ms window. The limit is a plain input, because the configuration registers live elsewhere.

Top module: `storm_limiter`

## Requirements
- R1: At 100 Mb/s (`speed_fast` = 1), a new window starts every `WIN_FAST` cycles. The first window starts when reset is released.
- R2: At 10 Mb/s (`speed_fast` = 0), a window lasts exactly 10 × `WIN_FAST` cycles.
- R3: The count of accepted frames returns to zero at the start of every window, so frames are accepted again after a window in which frames were dropped.
- R4: Within a window, the first `storm_limit` qualifying frames are accepted. Every later qualifying frame in that window has `frame_drop` = 1. A limit of 0 drops every qualifying frame.
- R5: When `port_limit_en` = 0, no frame qualifies: `frame_seen` and `frame_drop` stay 0, and the count is not changed.
- R6: A frame qualifies if `frame_bcast` = 1, or if `frame_mcast` = 1 and `mcast_incl` = 1.
- R7: A frame with neither flag set never qualifies. The same holds for a multicast-only frame when `mcast_incl` = 0. Such frames are never counted or dropped.
- R8: A frame whose start falls on the last cycle of a window is counted in the new window, against a count of zero.
- R9: `frame_seen` (frame qualified) and `frame_drop` are registered. Each is valid for the one cycle after the clock edge that samples `frame_sof`. Both are 0 when no frame started.
- R10: During reset and right after it, `frame_seen` and `frame_drop` are 0 and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sof | input | 1 | One-cycle strobe: a received frame starts |
| frame_bcast | input | 1 | Frame has a broadcast destination |
| frame_mcast | input | 1 | Frame has a multicast destination |
| port_limit_en | input | 1 | Enables limiting on this port |
| mcast_incl | input | 1 | Global option: also count and limit multicast frames |
| storm_limit | input | 11 | Global limit of accepted frames per window |
| speed_fast | input | 1 | 1 = 100 Mb/s window, 0 = 10 Mb/s window |
| frame_seen | output | 1 | Registered: the last frame start qualified |
| frame_drop | output | 1 | Registered: the last qualifying frame must be dropped |

## Verification
The bench places a frame on the last cycle of a window and then a second frame right after it, with a limit of 1.

- A design that charged the boundary frame to the old window would drop it.
- A design that left the new window's count at zero would accept the frame that follows.

Runs of back-to-back broadcasts around the limit, plus a limit of zero, expose off-by-one compares and counters that keep counting past the limit. The slow-speed run sends a frame after the fast window would have ended but inside the tenfold window; a timer that ignored speed would wrongly accept it. Disabled-port and unicast frames are sent while the count sits at the limit, which shows whether they leak into the count or get dropped.

// File: rtl/storm_pkg.sv
package storm_pkg;
    localparam int LIMIT_W    = 11;
    localparam int SLOW_RATIO = 10;

    typedef logic [LIMIT_W-1:0] limit_t;

    typedef struct packed {
        logic seen;
        logic drop;
    } verdict_t;
endpackage

// File: rtl/storm_window.sv
module storm_window
    import storm_pkg::*;
#(
    parameter int WIN_FAST = 8_375_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_fast,
    output logic restart
);
    localparam int WIN_SLOW = WIN_FAST * SLOW_RATIO;
    localparam int TMR_W    = $clog2(WIN_SLOW);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
    } win_state_t;

    win_state_t state_d, state_q;
    logic [TMR_W-1:0] last_tick;

    always_comb begin
        state_d   = state_q;
        last_tick = speed_fast ? TMR_W'(WIN_FAST - 1) : TMR_W'(WIN_SLOW - 1);
        // >= also covers a change from slow to fast speed in mid-window
        restart   = (state_q.tmr >= last_tick);
        if (restart) begin
            state_d.tmr = '0;
        end else begin
            state_d.tmr = state_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_tmr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.tmr <= TMR_W'(WIN_SLOW - 1))
        else $error("window timer beyond slow window length");

    assert_fast_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_fast && state_q.tmr == TMR_W'(WIN_FAST - 1)) |=> (state_q.tmr == '0))
        else $error("fast window did not wrap at its length");
endmodule

// File: rtl/storm_qualify.sv
module storm_qualify (
    input  logic sof,
    input  logic is_bcast,
    input  logic is_mcast,
    input  logic enable,
    input  logic mcast_incl,
    output logic qualify
);
    logic class_hit;

    always_comb begin
        class_hit = is_bcast | (is_mcast & mcast_incl);
        qualify   = sof & enable & class_hit;
    end
endmodule

// File: rtl/storm_meter.sv
module storm_meter
    import storm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     qualify,
    input  limit_t   limit,
    output verdict_t verdict
);
    typedef struct packed {
        limit_t   cnt;
        verdict_t vd;
    } meter_state_t;

    meter_state_t state_d, state_q;
    limit_t       base;
    logic         over;

    always_comb begin
        state_d = state_q;
        // a frame on the restart cycle is judged against the fresh window
        base    = restart ? '0 : state_q.cnt;
        over    = (base >= limit);
        state_d.cnt     = base + limit_t'(qualify && !over);
        state_d.vd.seen = qualify;
        state_d.vd.drop = qualify && over;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign verdict = state_q.vd;

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q.cnt <= limit_t'(1)))
        else $error("count not cleared at window start");

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !qualify |=> (!verdict.seen && !verdict.drop))
        else $error("verdict raised without a qualifying frame");

    assert_drop_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.drop |-> verdict.seen)
        else $error("drop without a qualifying frame");

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!qualify && !restart) |=> $stable(state_q.cnt))
        else $error("count moved without a qualifying frame");
endmodule

// File: rtl/storm_limiter.sv
module storm_limiter
    import storm_pkg::*;
#(
    parameter int WIN_FAST = 8_375_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_sof,
    input  logic        frame_bcast,
    input  logic        frame_mcast,
    input  logic        port_limit_en,
    input  logic        mcast_incl,
    input  logic [10:0] storm_limit,
    input  logic        speed_fast,
    output logic        frame_seen,
    output logic        frame_drop
);
    logic     win_restart;
    logic     qual;
    verdict_t vd;

    storm_window #(.WIN_FAST(WIN_FAST)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_fast (speed_fast),
        .restart    (win_restart)
    );

    storm_qualify u_qualify (
        .sof        (frame_sof),
        .is_bcast   (frame_bcast),
        .is_mcast   (frame_mcast),
        .enable     (port_limit_en),
        .mcast_incl (mcast_incl),
        .qualify    (qual)
    );

    storm_meter u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_restart),
        .qualify (qual),
        .limit   (storm_limit),
        .verdict (vd)
    );

    assign frame_seen = vd.seen;
    assign frame_drop = vd.drop;

    assert_no_drop_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sof && !port_limit_en) |=> !frame_drop)
        else $error("drop on a disabled port");
endmodule

// File: tb/storm_limiter_test.sv
`timescale 1ns/1ps
module storm_limiter_test;
    localparam int WIN = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sof = 1'b0;
    logic        frame_bcast = 1'b0;
    logic        frame_mcast = 1'b0;
    logic        port_limit_en = 1'b1;
    logic        mcast_incl = 1'b0;
    logic [10:0] storm_limit = 11'd2047;
    logic        speed_fast = 1'b1;
    logic        frame_seen;
    logic        frame_drop;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    logic got_seen, got_drop;

    storm_limiter #(.WIN_FAST(WIN)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_sof     (frame_sof),
        .frame_bcast   (frame_bcast),
        .frame_mcast   (frame_mcast),
        .port_limit_en (port_limit_en),
        .mcast_incl    (mcast_incl),
        .storm_limit   (storm_limit),
        .speed_fast    (speed_fast),
        .frame_seen    (frame_seen),
        .frame_drop    (frame_drop)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // {bcast, mcast, mcast_incl, enable, expected seen}
    localparam logic [4:0] VEC [8] = '{
        5'b1_0_0_1_1, 5'b0_1_0_1_0, 5'b0_1_1_1_1, 5'b1_1_0_1_1,
        5'b0_0_1_1_0, 5'b0_0_0_1_0, 5'b1_0_1_0_0, 5'b0_1_1_0_0
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_sof = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drives a frame start now (caller is at a negedge), samples the verdict
    task automatic fire(input logic bc, input logic mc);
        frame_sof = 1'b1;
        frame_bcast = bc;
        frame_mcast = mc;
        @(posedge clk);
        #1;
        got_seen = frame_seen;
        got_drop = frame_drop;
        frame_sof = 1'b0;
    endtask

    task automatic send(input logic bc, input logic mc);
        @(negedge clk);
        fire(bc, mc);
    endtask

    task automatic send_at(input int t, input logic bc, input logic mc);
        do @(negedge clk); while (cyc != t);
        fire(bc, mc);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R10 seen in reset", frame_seen, 1'b0);
        check("R10 drop in reset", frame_drop, 1'b0);
        do_reset();
        #1;
        check("R10 seen after reset", frame_seen, 1'b0);
        check("R10 drop after reset", frame_drop, 1'b0);

        // classification table, limit high so nothing drops
        storm_limit = 11'd2047;
        for (int i = 0; i < 8; i++) begin
            mcast_incl    = VEC[i][2];
            port_limit_en = VEC[i][1];
            send(VEC[i][4], VEC[i][3]);
            check("R5/R6/R7 qualify", got_seen, VEC[i][0]);
            check("R5/R6/R7 no drop", got_drop, 1'b0);
        end
        port_limit_en = 1'b1;
        mcast_incl = 1'b0;

        // R9: verdict lasts one cycle only
        @(negedge clk);
        check("R9 seen clears", frame_seen, 1'b0);

        // R4: limit 3, five back-to-back broadcasts
        storm_limit = 11'd3;
        do_reset();
        send_at(2, 1'b1, 1'b0);
        check("R4 frame1 accepted", got_drop, 1'b0);
        send(1'b1, 1'b0); check("R4 frame2 accepted", got_drop, 1'b0);
        send(1'b1, 1'b0); check("R4 frame3 accepted", got_drop, 1'b0);
        send(1'b1, 1'b0); check("R4 frame4 dropped", got_drop, 1'b1);
        send(1'b1, 1'b0); check("R4 frame5 dropped", got_drop, 1'b1);
        send(1'b0, 1'b0);
        check("R7 unicast at limit seen", got_seen, 1'b0);
        check("R7 unicast at limit drop", got_drop, 1'b0);
        send(1'b0, 1'b1);
        check("R7 mcast excluded drop", got_drop, 1'b0);
        send_at(WIN + 1, 1'b1, 1'b0);
        check("R3 accepted in next window", got_drop, 1'b0);
        check("R1 seen in next window", got_seen, 1'b1);

        // R8: frame on the restart cycle belongs to the new window
        storm_limit = 11'd1;
        do_reset();
        send_at(5, 1'b1, 1'b0);
        check("R8 first frame accepted", got_drop, 1'b0);
        send(1'b1, 1'b0);
        check("R8 second frame dropped", got_drop, 1'b1);
        send_at(WIN - 1, 1'b1, 1'b0);
        check("R8 restart-cycle frame accepted", got_drop, 1'b0);
        send(1'b1, 1'b0);
        check("R8 frame after restart dropped", got_drop, 1'b1);

        // R2: slow window is ten times longer
        speed_fast = 1'b0;
        do_reset();
        send_at(2, 1'b1, 1'b0);
        check("R2 slow first accepted", got_drop, 1'b0);
        send_at(WIN * 2 + 20, 1'b1, 1'b0);
        check("R2 slow same window dropped", got_drop, 1'b1);
        send_at(WIN * 10 + 2, 1'b1, 1'b0);
        check("R2 slow next window accepted", got_drop, 1'b0);
        speed_fast = 1'b1;

        // R5: disabled frames do not consume the budget
        storm_limit = 11'd1;
        do_reset();
        port_limit_en = 1'b0;
        send_at(2, 1'b1, 1'b0);
        check("R5 disabled no drop", got_drop, 1'b0);
        send(1'b1, 1'b0);
        send(1'b1, 1'b0);
        check("R5 disabled not seen", got_seen, 1'b0);
        port_limit_en = 1'b1;
        send(1'b1, 1'b0);
        check("R5 enabled frame accepted", got_drop, 1'b0);

        // R6: multicast counted when included
        do_reset();
        mcast_incl = 1'b1;
        send_at(2, 1'b0, 1'b1);
        check("R6 mcast accepted", got_drop, 1'b0);
        send(1'b1, 1'b0);
        check("R6 bcast after mcast dropped", got_drop, 1'b1);
        mcast_incl = 1'b0;

        // R4: limit zero drops everything
        storm_limit = 11'd0;
        do_reset();
        send_at(2, 1'b1, 1'b0);
        check("R4 limit zero drop", got_drop, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule